// File: doc/BRIEF.md
# RISC Integer Execution Unit with Barrel Shifter

This block is the purely combinational integer datapath of a small load/store RISC core. Each cycle the issue stage presents two register operands, a shift-amount field taken from the instruction and a 5-bit operation code. The unit returns the result word, a write qualifier for the destination register and a trap flag for signed overflow. Sign or zero extension of immediates happens before the operands arrive, so an immediate-form instruction simply uses the same operation code as its register form.

The supported operations are:

- addition and subtraction, each in a trapping and a non-trapping form;
- the four bitwise functions;
- signed and unsigned compare-and-set;
- the upper-half constant load;
- six shifts: left logical, right logical and right arithmetic, each with either a fixed amount or a register-held amount.

The subtract path of the adder also produces both compare results. A single right-shifting barrel network serves every shift direction.

Top module: `risc_exec_alu`

## Requirements
- R1: For the trapping add (code 0) and trapping subtract (code 2), `ovf_trap_o` is 1 exactly when the true signed sum or difference of the two operands falls outside the 32-bit two's-complement range. When the trap fires, `wr_en_o` is 0. `result_o` always carries the wrapped 32-bit value.
- R2: The non-trapping add (code 1) and non-trapping subtract (code 3) produce the same wrapped result as their trapping forms. For these two codes `ovf_trap_o` is always 0 and `wr_en_o` is always 1. No operation other than codes 0 and 2 ever raises `ovf_trap_o`.
- R3: Code 4 returns `src_a_i` AND `src_b_i`, code 5 returns OR, code 6 returns XOR, and code 7 returns NOR. For example, 0xabcd1234 with 0xffff0000 gives 0xabcd0000, 0xffff1234, 0x54321234 and 0x0000edcb respectively.
- R4: Code 8 (signed) and code 9 (unsigned) return 1 when `src_a_i` is less than `src_b_i`, and 0 otherwise. Bits 31..1 of the result are always zero. With operands 1 and 0xffffffff, code 8 gives 0 and code 9 gives 1.
- R5: The fixed-amount shifts shift `src_b_i` by `shamt_i` and ignore `src_a_i`:
  - code 11 is left logical, with zeros entering at the bottom;
  - code 12 is right logical, with zeros entering at the top;
  - code 13 is right arithmetic, with copies of bit 31 entering at the top.
  
  For 0xabcd1234, a left shift by 8 gives 0xcd123400 and an arithmetic right shift by 4 gives 0xfabcd123. A shift by 0 returns `src_b_i` unchanged.
- R6: The register-amount shifts (code 14 left logical, code 15 right logical, code 16 right arithmetic) shift `src_b_i` by `src_a_i[4:0]`. They ignore `src_a_i[31:5]` and `shamt_i`. For 0xabcd1234 shifted right logically by 16, the result is 0x0000abcd.
- R7: Code 10 returns `src_b_i[15:0]` in bits 31..16 and zero in bits 15..0.
- R8: The codes are 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 SLT, 9 SLTU, 10 UPPER, 11 SLL, 12 SRL, 13 SRA, 14 SLLV, 15 SRLV and 16 SRAV. Every defined code without a trap drives `wr_en_o` to 1. Codes 17 to 31 drive `result_o` to 0 and both `wr_en_o` and `ovf_trap_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (see R8) |
| src_a_i | input | 32 | First operand; supplies the shift amount for register shifts |
| src_b_i | input | 32 | Second operand; the value that is shifted, or the constant for the upper load |
| shamt_i | input | 5 | Fixed shift amount from the instruction |
| result_o | output | 32 | Result word |
| wr_en_o | output | 1 | Destination write qualifier |
| ovf_trap_o | output | 1 | Signed-overflow trap request |

## Verification
The add and subtract paths are tried with operands at and next to 0x7fffffff and 0x80000000, including zero minus the most negative value. These patterns separate a correct overflow rule from one that only looks at carry-out or that negates the second operand naively. The compare operations get operand pairs whose signed and unsigned orderings disagree, which shows whether the two kinds of comparison are kept apart. The shifts use sign-set and sign-clear words at amounts 0, 4, 8, 16 and 31, and the register-amount forms also get amounts with junk in the upper bits and a conflicting fixed field. Beyond these directed cases, a long pseudo-random sweep over every code, biased toward the boundary words, is compared against an arithmetic reference model written independently in the bench.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  // Operation codes; the numeric values are part of the interface.
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_UPR  = 5'd10,
    OP_SLL  = 5'd11,
    OP_SRL  = 5'd12,
    OP_SRA  = 5'd13,
    OP_SLLV = 5'd14,
    OP_SRLV = 5'd15,
    OP_SRAV = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LL = 2'd0,
    SH_RL = 2'd1,
    SH_RA = 2'd2
  } sh_kind_e;

  typedef enum logic [2:0] {
    RES_NONE  = 3'd0,
    RES_ARITH = 3'd1,
    RES_LOGIC = 3'd2,
    RES_CMP   = 3'd3,
    RES_UPPER = 3'd4,
    RES_SHIFT = 3'd5
  } res_sel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

  typedef struct packed {
    logic      valid;
    logic      sub_mode;
    logic      trap_en;
    logic      cmp_uns;
    logic      sh_var;
    sh_kind_e  sh_kind;
    logic_fn_e lg_fn;
    res_sel_e  res_sel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
`timescale 1ns/1ps
module alu_decode
  import alu_pkg::*;
(
  input  logic [4:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.sh_kind  = SH_LL;
    ctrl_o.lg_fn    = LG_AND;
    ctrl_o.res_sel  = RES_NONE;
    ctrl_o.valid    = 1'b1;
    case (op_i)
      OP_ADD:  begin ctrl_o.res_sel = RES_ARITH; ctrl_o.trap_en = 1'b1; end
      OP_ADDU: begin ctrl_o.res_sel = RES_ARITH; end
      OP_SUB:  begin ctrl_o.res_sel = RES_ARITH; ctrl_o.sub_mode = 1'b1; ctrl_o.trap_en = 1'b1; end
      OP_SUBU: begin ctrl_o.res_sel = RES_ARITH; ctrl_o.sub_mode = 1'b1; end
      OP_AND:  begin ctrl_o.res_sel = RES_LOGIC; ctrl_o.lg_fn = LG_AND; end
      OP_OR:   begin ctrl_o.res_sel = RES_LOGIC; ctrl_o.lg_fn = LG_OR;  end
      OP_XOR:  begin ctrl_o.res_sel = RES_LOGIC; ctrl_o.lg_fn = LG_XOR; end
      OP_NOR:  begin ctrl_o.res_sel = RES_LOGIC; ctrl_o.lg_fn = LG_NOR; end
      OP_SLT:  begin ctrl_o.res_sel = RES_CMP; ctrl_o.sub_mode = 1'b1; end
      OP_SLTU: begin ctrl_o.res_sel = RES_CMP; ctrl_o.sub_mode = 1'b1; ctrl_o.cmp_uns = 1'b1; end
      OP_UPR:  begin ctrl_o.res_sel = RES_UPPER; end
      OP_SLL:  begin ctrl_o.res_sel = RES_SHIFT; ctrl_o.sh_kind = SH_LL; end
      OP_SRL:  begin ctrl_o.res_sel = RES_SHIFT; ctrl_o.sh_kind = SH_RL; end
      OP_SRA:  begin ctrl_o.res_sel = RES_SHIFT; ctrl_o.sh_kind = SH_RA; end
      OP_SLLV: begin ctrl_o.res_sel = RES_SHIFT; ctrl_o.sh_kind = SH_LL; ctrl_o.sh_var = 1'b1; end
      OP_SRLV: begin ctrl_o.res_sel = RES_SHIFT; ctrl_o.sh_kind = SH_RL; ctrl_o.sh_var = 1'b1; end
      OP_SRAV: begin ctrl_o.res_sel = RES_SHIFT; ctrl_o.sh_kind = SH_RA; ctrl_o.sh_var = 1'b1; end
      default: begin ctrl_o.valid = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   full;

  // Subtraction is a + ~b + 1, with the increment folded into the carry-in.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];

  // Overflow: the addends agree in sign but the sum does not.
  assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);

  // Valid when subtracting: signed order from sign xor overflow, unsigned from borrow.
  assign lt_s_o = sum_o[W-1] ^ ovf_o;
  assign lt_u_o = ~full[W];

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
`timescale 1ns/1ps
module alu_shift
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  sh_kind_e      kind_i,
  output logic [W-1:0]  y_o
);

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic         go_left;
  logic         fill;
  logic [W-1:0] stage [0:SW];

  // Left shifts run through the right-shift network on bit-reversed data.
  assign go_left  = (kind_i == SH_LL);
  assign fill     = (kind_i == SH_RA) & data_i[W-1];
  assign stage[0] = go_left ? flip(data_i) : data_i;

  for (genvar g = 0; g < SW; g++) begin : g_stage
    localparam int STEP = 1 << g;
    assign stage[g+1] = amt_i[g] ? {{STEP{fill}}, stage[g][W-1:STEP]} : stage[g];
  end

  assign y_o = go_left ? flip(stage[SW]) : stage[SW];

endmodule

// File: rtl/risc_exec_alu.sv
`timescale 1ns/1ps
module risc_exec_alu
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [XLEN-1:0] result_o,
  output logic            wr_en_o,
  output logic            ovf_trap_o
);

  localparam int HALF = XLEN / 2;

  alu_ctrl_t       ctrl;
  logic [XLEN-1:0] sum_w;
  logic            ovf_w;
  logic            lt_s_w;
  logic            lt_u_w;
  logic [XLEN-1:0] logic_w;
  logic [XLEN-1:0] shift_w;
  logic [SHW-1:0]  sh_amt;
  logic            cmp_bit;

  alu_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  alu_addsub #(.W(XLEN)) u_add (
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .sub_i  (ctrl.sub_mode),
    .sum_o  (sum_w),
    .ovf_o  (ovf_w),
    .lt_s_o (lt_s_w),
    .lt_u_o (lt_u_w)
  );

  alu_logic #(.W(XLEN)) u_lg (
    .a_i  (src_a_i),
    .b_i  (src_b_i),
    .fn_i (ctrl.lg_fn),
    .y_o  (logic_w)
  );

  assign sh_amt = ctrl.sh_var ? src_a_i[SHW-1:0] : shamt_i;

  alu_shift #(.W(XLEN), .SW(SHW)) u_sh (
    .data_i (src_b_i),
    .amt_i  (sh_amt),
    .kind_i (ctrl.sh_kind),
    .y_o    (shift_w)
  );

  assign cmp_bit = ctrl.cmp_uns ? lt_u_w : lt_s_w;

  always_comb begin
    case (ctrl.res_sel)
      RES_ARITH: result_o = sum_w;
      RES_LOGIC: result_o = logic_w;
      RES_CMP:   result_o = {{(XLEN-1){1'b0}}, cmp_bit};
      RES_UPPER: result_o = {src_b_i[HALF-1:0], {HALF{1'b0}}};
      RES_SHIFT: result_o = shift_w;
      default:   result_o = '0;
    endcase
  end

  assign ovf_trap_o = ctrl.trap_en & ovf_w;
  assign wr_en_o    = ctrl.valid & ~ovf_trap_o;

endmodule

// File: rtl/risc_exec_alu_chk.sv
`timescale 1ns/1ps
module risc_exec_alu_chk
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] src_a_i,
  input logic [XLEN-1:0] src_b_i,
  input logic [SHW-1:0]  shamt_i,
  input logic [XLEN-1:0] result_o,
  input logic            wr_en_o,
  input logic            ovf_trap_o
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] a_seen;
  assign a_seen = src_a_i;

  always_comb begin
    if (ovf_trap_o) AST_TRAP_NO_WRITE: assert (!wr_en_o); // R1
    if (op_i != OP_ADD && op_i != OP_SUB) AST_QUIET_NO_TRAP: assert (!ovf_trap_o); // R2
    if (op_i == OP_SLT || op_i == OP_SLTU) AST_CMP_ONE_BIT: assert (result_o[XLEN-1:1] == '0); // R4
    if (op_i == OP_UPR) AST_UPPER_LOW_CLEAR: assert (result_o[HALF-1:0] == '0 && result_o[XLEN-1:HALF] == src_b_i[HALF-1:0]); // R7
    if ((op_i == OP_SLL || op_i == OP_SRL || op_i == OP_SRA) && shamt_i == '0) AST_ZERO_SHIFT_IDENT: assert (result_o == src_b_i); // R5
    if ((op_i == OP_SLLV || op_i == OP_SRLV || op_i == OP_SRAV) && a_seen[SHW-1:0] == '0) AST_ZERO_VSHIFT_IDENT: assert (result_o == src_b_i); // R6
    if (op_i > OP_SRAV) AST_UNUSED_INERT: assert (!wr_en_o && !ovf_trap_o && result_o == '0); // R8
  end

endmodule

bind risc_exec_alu risc_exec_alu_chk #(.XLEN(XLEN), .SHW(SHW)) u_chk (
  .op_i       (op_i),
  .src_a_i    (src_a_i),
  .src_b_i    (src_b_i),
  .shamt_i    (shamt_i),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .ovf_trap_o (ovf_trap_o)
);

// File: tb/risc_exec_alu_tb.sv
`timescale 1ns/1ps
module risc_exec_alu_tb;
  import alu_pkg::*;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [4:0]   op;
  logic [W-1:0] a, b;
  logic [4:0]   sh;
  logic [W-1:0] result;
  logic         wen, trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [4:0]   op;
    logic [W-1:0] a, b;
    logic [4:0]   sh;
    logic [W-1:0] res;
    logic         wen, trap;
    string        tag;
  } item_t;

  item_t q[$];

  risc_exec_alu u_dut (
    .op_i       (op),
    .src_a_i    (a),
    .src_b_i    (b),
    .shamt_i    (sh),
    .result_o   (result),
    .wr_en_o    (wen),
    .ovf_trap_o (trap)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd2:                   return "R1";
      5'd1, 5'd3:                   return "R2";
      5'd4, 5'd5, 5'd6, 5'd7:       return "R3";
      5'd8, 5'd9:                   return "R4";
      5'd10:                        return "R7";
      5'd11, 5'd12, 5'd13:          return "R5";
      5'd14, 5'd15, 5'd16:          return "R6";
      default:                      return "R8";
    endcase
  endfunction

  // Independent reference model built from the requirements.
  function automatic item_t model(input logic [4:0] o, input logic [W-1:0] x,
                                  input logic [W-1:0] y, input logic [4:0] s);
    item_t  it;
    longint wide;
    logic   ov;
    it.op = o; it.a = x; it.b = y; it.sh = s;
    it.wen = 1'b1; it.trap = 1'b0; it.res = '0; it.tag = tag_of(o);
    case (o)
      5'd0, 5'd1, 5'd2, 5'd3: begin
        if (o[1]) begin
          it.res = x - y;
          wide   = longint'($signed(x)) - longint'($signed(y));
        end else begin
          it.res = x + y;
          wide   = longint'($signed(x)) + longint'($signed(y));
        end
        ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        if (!o[0] && ov) begin it.trap = 1'b1; it.wen = 1'b0; end
      end
      5'd4:  it.res = x & y;
      5'd5:  it.res = x | y;
      5'd6:  it.res = x ^ y;
      5'd7:  it.res = ~(x | y);
      5'd8:  it.res = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      5'd9:  it.res = (x < y) ? 32'd1 : 32'd0;
      5'd10: it.res = {y[15:0], 16'h0000};
      5'd11: it.res = y << s;
      5'd12: it.res = y >> s;
      5'd13: it.res = $unsigned($signed(y) >>> s);
      5'd14: it.res = y << x[4:0];
      5'd15: it.res = y >> x[4:0];
      5'd16: it.res = $unsigned($signed(y) >>> x[4:0]);
      default: begin it.res = '0; it.wen = 1'b0; end
    endcase
    return it;
  endfunction

  task automatic drive_item(input item_t it);
    @(posedge clk);
    #1;
    op = it.op; a = it.a; b = it.b; sh = it.sh;
    q.push_back(it);
  endtask

  task automatic drive_exp(input logic [4:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                           input logic [4:0] s, input logic [W-1:0] r, input logic w,
                           input logic t, input string tg);
    item_t it;
    it.op = o; it.a = x; it.b = y; it.sh = s;
    it.res = r; it.wen = w; it.trap = t; it.tag = tg;
    drive_item(it);
  endtask

  task automatic drive_model(input logic [4:0] o, input logic [W-1:0] x,
                             input logic [W-1:0] y, input logic [4:0] s);
    drive_item(model(o, x, y, s));
  endtask

  // Monitor: compares the settled outputs at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (result !== it.res || wen !== it.wen || trap !== it.trap) begin
          fails++;
          $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h wen=%b trap=%b, expected res=%h wen=%b trap=%b",
                   it.tag, it.op, it.a, it.b, it.sh, result, wen, trap, it.res, it.wen, it.trap);
        end
      end
    end
  end

  function automatic logic [31:0] xs32(input logic [31:0] v);
    logic [31:0] r;
    r = v ^ (v << 13);
    r = r ^ (r >> 17);
    r = r ^ (r << 5);
    return r;
  endfunction

  function automatic logic [31:0] bias(input logic [31:0] r);
    case (r[2:0])
      3'd0: return 32'h7fffffff;
      3'd1: return 32'h80000000;
      3'd2: return 32'hffffffff;
      3'd3: return 32'h00000001;
      default: return r;
    endcase
  endfunction

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0;
    op = '0; a = '0; b = '0; sh = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // Idle state after reset: zero operands with code 0 (R1).
    drive_exp(5'd0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b1, 1'b0, "R1 idle");

    // R1: trapping overflow corners.
    drive_exp(5'd0, 32'h7fffffff, 32'h1, 5'd0, 32'h80000000, 1'b0, 1'b1, "R1 add max+1");
    drive_exp(5'd0, 32'h80000000, 32'h80000000, 5'd0, 32'h0, 1'b0, 1'b1, "R1 add min+min");
    drive_exp(5'd0, 32'h7fffffff, 32'h80000000, 5'd0, 32'hffffffff, 1'b1, 1'b0, "R1 add mixed sign");
    drive_exp(5'd2, 32'h80000000, 32'h1, 5'd0, 32'h7fffffff, 1'b0, 1'b1, "R1 sub min-1");
    drive_exp(5'd2, 32'h0, 32'h80000000, 5'd0, 32'h80000000, 1'b0, 1'b1, "R1 sub 0-min");
    drive_exp(5'd2, 32'hffffffff, 32'h7fffffff, 5'd0, 32'h80000000, 1'b1, 1'b0, "R1 sub -1-max");

    // R2: non-trapping forms never trap.
    drive_exp(5'd1, 32'h7fffffff, 32'h1, 5'd0, 32'h80000000, 1'b1, 1'b0, "R2 addu wrap");
    drive_exp(5'd3, 32'h0, 32'h80000000, 5'd0, 32'h80000000, 1'b1, 1'b0, "R2 subu wrap");

    // R3: bitwise functions.
    drive_exp(5'd4, 32'habcd1234, 32'hffff0000, 5'd0, 32'habcd0000, 1'b1, 1'b0, "R3 and");
    drive_exp(5'd5, 32'habcd1234, 32'hffff0000, 5'd0, 32'hffff1234, 1'b1, 1'b0, "R3 or");
    drive_exp(5'd6, 32'habcd1234, 32'hffff0000, 5'd0, 32'h54321234, 1'b1, 1'b0, "R3 xor");
    drive_exp(5'd7, 32'habcd1234, 32'hffff0000, 5'd0, 32'h0000edcb, 1'b1, 1'b0, "R3 nor");

    // R4: compare signedness.
    drive_exp(5'd8, 32'h1, 32'hffffffff, 5'd0, 32'h0, 1'b1, 1'b0, "R4 slt");
    drive_exp(5'd9, 32'h1, 32'hffffffff, 5'd0, 32'h1, 1'b1, 1'b0, "R4 sltu");
    drive_exp(5'd8, 32'h80000000, 32'h7fffffff, 5'd0, 32'h1, 1'b1, 1'b0, "R4 slt min<max");

    // R5: fixed-amount shifts, with junk on src_a.
    drive_exp(5'd11, 32'hdeadbeef, 32'habcd1234, 5'd8, 32'hcd123400, 1'b1, 1'b0, "R5 sll 8");
    drive_exp(5'd13, 32'hdeadbeef, 32'habcd1234, 5'd4, 32'hfabcd123, 1'b1, 1'b0, "R5 sra 4");
    drive_exp(5'd12, 32'h0, 32'h80000000, 5'd31, 32'h1, 1'b1, 1'b0, "R5 srl 31");
    drive_exp(5'd13, 32'h0, 32'h80000000, 5'd31, 32'hffffffff, 1'b1, 1'b0, "R5 sra 31");
    drive_exp(5'd11, 32'h0, 32'h1, 5'd31, 32'h80000000, 1'b1, 1'b0, "R5 sll 31");

    // R6: register-amount shifts ignore upper amount bits and the fixed field.
    drive_exp(5'd15, 32'h10, 32'habcd1234, 5'd0, 32'h0000abcd, 1'b1, 1'b0, "R6 srlv 16");
    drive_exp(5'd15, 32'hfffffff0, 32'habcd1234, 5'd3, 32'h0000abcd, 1'b1, 1'b0, "R6 srlv upper bits");
    drive_exp(5'd16, 32'h00000104, 32'habcd1234, 5'd9, 32'hfabcd123, 1'b1, 1'b0, "R6 srav");
    drive_exp(5'd14, 32'hffffffe0, 32'habcd1234, 5'd7, 32'habcd1234, 1'b1, 1'b0, "R6 sllv amount 0");

    // R7: upper-half constant load.
    drive_exp(5'd10, 32'h12345678, 32'h1234ac51, 5'd5, 32'hac510000, 1'b1, 1'b0, "R7 upper");

    // R8: unused codes are inert.
    drive_exp(5'd17, 32'h7fffffff, 32'h1, 5'd3, 32'h0, 1'b0, 1'b0, "R8 code 17");
    drive_exp(5'd31, 32'hffffffff, 32'hffffffff, 5'd31, 32'h0, 1'b0, 1'b0, "R8 code 31");

    // Sweep of every code against the reference model.
    seed = 32'h1badf00d;
    for (int i = 0; i < 80; i++) begin
      for (int o = 0; o < 20; o++) begin
        logic [31:0] x, y;
        seed = xs32(seed); x = bias(seed);
        seed = xs32(seed); y = bias(seed);
        seed = xs32(seed);
        drive_model(5'(o), x, y, seed[4:0]);
      end
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule